// File: doc/BRIEF.md
# Latency Statistics Accumulator

This block times repeated start/finish event pairs in clock cycles and keeps the statistics that software needs for the mean and standard deviation of that latency. For each measurement channel it holds how many measurements have completed, the running sum of latencies, the running sum of squared latencies, and the smallest and largest latency seen since the last clear. Software computes the mean and spread from these values. Each channel has at most one measurement open at a time.

Accumulation is gated by a shared run state. Command pulses or cross-trigger pulses set and clear that state. A clear command wipes every statistic. A sample command copies all statistics of all channels into a read buffer in the same cycle. The buffer is then read word by word through a port that steps to the next word on every read strobe, so counting can go on while software reads a stable copy.

Top module: `lat_stat_acc`

## Requirements
- R1: A pulse on `cmd_go` or `trig_go` turns the run state on, and a pulse on `cmd_halt` or `trig_halt` turns it off. Halt wins when both arrive in the same cycle. A measurement opens only while the run state is on. A finish is recorded only while the run state is on, but it closes the open measurement in either case.
- R2: The latency is the number of clock edges between the cycle that carries the accepted start and the cycle that carries the finish. A start and a finish in the same cycle record a latency of 0.
- R3: Each recorded measurement adds 1 to the count word and adds L to the sum word. Both wrap modulo 2^CNT_W.
- R4: The sum of squares is 2*CNT_W bits wide. Each recorded measurement adds L*L to it. It is read as two words, low half first.
- R5: The minimum word holds the smallest recorded latency and the maximum word holds the largest. After reset or clear, the minimum is all ones and the maximum is zero.
- R6: A start that arrives while a measurement is open is ignored, and timing continues from the original start. A finish that arrives with no open measurement is ignored.
- R7: A `cmd_clear` pulse returns every channel's statistics to the reset values and abandons any open measurement. A finish in the same cycle as the clear is not recorded.
- R8: A `cmd_sample` pulse captures all words of all channels in the same cycle. The read port keeps returning the captured copy, unchanged, until the next sample, while measurement goes on.
- R9: After a sample, `rd_data` shows word 0. Each cycle with `rd_next` high steps to the next word, and the word after the last is word 0 again. The word order is channel 0 first, and within a channel: count, sum, squares low, squares high, minimum, maximum. A sample in the same cycle as `rd_next` sets the read position to word 0.
- R10: NUM_CH independent channels run side by side, each with its own start and finish bits, and measurements on different channels may overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_go | input | 1 | Command pulse: turn the run state on |
| cmd_halt | input | 1 | Command pulse: turn the run state off |
| cmd_clear | input | 1 | Command pulse: clear all statistics |
| cmd_sample | input | 1 | Command pulse: capture all statistics into the read buffer |
| trig_go | input | 1 | Cross-trigger pulse: turn the run state on |
| trig_halt | input | 1 | Cross-trigger pulse: turn the run state off |
| ev_start | input | NUM_CH | Per-channel start of the timed event |
| ev_finish | input | NUM_CH | Per-channel end of the timed event |
| rd_next | input | 1 | Step the read position to the next word |
| rd_data | output | CNT_W | Buffered word at the current read position |

## Verification
A start applied to the clock edge at t and a finish applied to the edge at t+L change the statistic registers at the finish edge. A sample pulse one cycle later copies them, and `rd_data` is valid half a cycle after that capture edge. Each later word appears one edge after `rd_next` is raised. The bench drives every input on the falling edge and reads `rd_data` on the falling edge that follows the edge where that word became due, so each compare falls a full half cycle away from the edge that changes it. The expected words come from an arithmetic model of count, sums, squares and extremes, taken modulo the word width and frozen at the moment of each sample.

// File: rtl/lat_stat_pkg.sv
package lat_stat_pkg;

  // Word order inside one channel of the read buffer.
  typedef enum logic [2:0] {
    ITM_COUNT = 3'd0,
    ITM_SUM   = 3'd1,
    ITM_SQ_LO = 3'd2,
    ITM_SQ_HI = 3'd3,
    ITM_MIN   = 3'd4,
    ITM_MAX   = 3'd5
  } item_e;

  localparam int WORDS_PER_CH = 6;

endpackage

// File: rtl/lat_run_ctrl.sv
module lat_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_go,
  input  logic cmd_halt,
  input  logic trig_go,
  input  logic trig_halt,
  output logic run_o
);

  logic run_q;
  logic run_d;
  logic halt_any;
  logic go_any;

  assign halt_any = cmd_halt | trig_halt;
  assign go_any   = cmd_go | trig_go;

  always_comb begin
    run_d = run_q;
    if (halt_any) begin
      run_d = 1'b0;
    end else if (go_any) begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  assign run_o = run_q;

  // R1: halt has priority over go
  a_r1_halt_wins : assert property (@(posedge clk) disable iff (!rst_n)
    halt_any |=> !run_o);

  // R1: a go with no halt turns the run state on
  a_r1_go_sets : assert property (@(posedge clk) disable iff (!rst_n)
    (go_any && !halt_any) |=> run_o);

endmodule

// File: rtl/lat_meas_chan.sv
module lat_meas_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             ev_start,
  input  logic             ev_finish,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] sum_o,
  output logic [CNT_W-1:0] sq_lo_o,
  output logic [CNT_W-1:0] sq_hi_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);

  localparam int SQ_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] ONE_W = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             open_q,    open_d;
  logic [CNT_W-1:0] elapsed_q, elapsed_d;
  logic [CNT_W-1:0] cnt_q,     cnt_d;
  logic [CNT_W-1:0] sum_q,     sum_d;
  logic [SQ_W-1:0]  sq_q,      sq_d;
  logic [CNT_W-1:0] min_q,     min_d;
  logic [CNT_W-1:0] max_q,     max_d;

  logic             accept_start;
  logic             finish_hit;
  logic             record;
  logic             stat_en;
  logic [CNT_W-1:0] lat;
  logic [SQ_W-1:0]  lat_wide;
  logic [SQ_W-1:0]  lat_sq;

  // A start opens a window only when idle and running.
  assign accept_start = run && ev_start && !open_q;
  // A finish ends an open window, or a window opened in the same cycle.
  assign finish_hit   = ev_finish && (open_q || accept_start);
  assign record       = run && finish_hit && !clear;
  assign lat          = open_q ? elapsed_q : '0;
  assign lat_wide     = {{CNT_W{1'b0}}, lat};
  assign lat_sq       = lat_wide * lat_wide;
  assign stat_en      = record || clear;

  // Window tracking.
  always_comb begin
    open_d    = open_q;
    elapsed_d = elapsed_q;
    if (clear) begin
      open_d = 1'b0;
    end else if (open_q && ev_finish) begin
      open_d = 1'b0;
    end else if (accept_start && !ev_finish) begin
      open_d    = 1'b1;
      elapsed_d = ONE_W;
    end else if (open_q && (elapsed_q != '1)) begin
      elapsed_d = elapsed_q + ONE_W;
    end
  end

  // Statistics.
  always_comb begin
    cnt_d = cnt_q;
    sum_d = sum_q;
    sq_d  = sq_q;
    min_d = min_q;
    max_d = max_q;
    if (clear) begin
      cnt_d = '0;
      sum_d = '0;
      sq_d  = '0;
      min_d = '1;
      max_d = '0;
    end else if (record) begin
      cnt_d = cnt_q + ONE_W;
      sum_d = sum_q + lat;
      sq_d  = sq_q + lat_sq;
      if (lat < min_q) min_d = lat;
      if (lat > max_q) max_d = lat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      elapsed_q <= '0;
    end else begin
      open_q    <= open_d;
      elapsed_q <= elapsed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
      sq_q  <= '0;
      min_q <= '1;
      max_q <= '0;
    end else if (stat_en) begin
      cnt_q <= cnt_d;
      sum_q <= sum_d;
      sq_q  <= sq_d;
      min_q <= min_d;
      max_q <= max_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign sum_o   = sum_q;
  assign sq_lo_o = sq_q[CNT_W-1:0];
  assign sq_hi_o = sq_q[SQ_W-1:CNT_W];
  assign min_o   = min_q;
  assign max_o   = max_q;

  // R2: start and finish together leave a zero minimum
  a_r2_zero_latency : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !open_q && ev_start && ev_finish && !clear) |=> (min_q == '0));

  // R3: a recorded finish steps the count by one
  a_r3_count_step : assert property (@(posedge clk) disable iff (!rst_n)
    (run && open_q && ev_finish && !clear) |=> (cnt_q == $past(cnt_q) + ONE_W));

  // R5: the extremes stay ordered once a measurement exists
  a_r5_min_le_max : assert property (@(posedge clk) disable iff (!rst_n)
    (max_q != '0) |-> (min_q <= max_q));

  // R6: an extra start does not restart an open window
  a_r6_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && ev_start && !ev_finish && !clear) |=> (open_q && (elapsed_q != ONE_W)));

  // R7: clear returns every statistic to its reset value
  a_r7_clear_resets : assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && sum_q == '0 && sq_q == '0 && min_q == '1 && max_q == '0 && !open_q));

endmodule

// File: rtl/lat_snap_port.sv
module lat_snap_port #(
  parameter int CNT_W = 32,
  parameter int ITEMS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample,
  input  logic                   rd_next,
  input  logic [ITEMS*CNT_W-1:0] live_i,
  output logic [CNT_W-1:0]       rd_data
);

  localparam int PW = (ITEMS > 1) ? $clog2(ITEMS) : 1;
  localparam logic [PW-1:0] LAST  = PW'(ITEMS - 1);
  localparam logic [PW-1:0] ONE_P = PW'(1);

  logic [CNT_W-1:0] live_w [ITEMS];
  logic [CNT_W-1:0] snap_q [ITEMS];
  logic [PW-1:0]    ptr_q, ptr_d;

  for (genvar i = 0; i < ITEMS; i++) begin : g_unpack
    assign live_w[i] = live_i[i*CNT_W +: CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q[i] <= '0;
      end else if (sample) begin
        snap_q[i] <= live_w[i];
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (sample) begin
      ptr_d = '0;
    end else if (rd_next) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + ONE_P;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign rd_data = snap_q[ptr_q];

  // R9: the read position wraps from the last word to word 0
  a_r9_ptr_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && !sample && ptr_q == LAST) |=> (ptr_q == '0));

  // R9: a sample resets the read position
  a_r9_sample_home : assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> (ptr_q == '0));

  // R8: without sample or step the output word holds
  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !rd_next) |=> $stable(rd_data));

endmodule

// File: rtl/lat_stat_acc.sv
module lat_stat_acc #(
  parameter int NUM_CH = 1,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_halt,
  input  logic              cmd_clear,
  input  logic              cmd_sample,
  input  logic              trig_go,
  input  logic              trig_halt,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_finish,
  input  logic              rd_next,
  output logic [CNT_W-1:0]  rd_data
);

  import lat_stat_pkg::*;

  localparam int ITEMS = NUM_CH * WORDS_PER_CH;

  logic [1:0]             rst_sync_q;
  logic                   rst_n_int;
  logic                   run;
  logic [ITEMS*CNT_W-1:0] live;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  lat_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_go    (cmd_go),
    .cmd_halt  (cmd_halt),
    .trig_go   (trig_go),
    .trig_halt (trig_halt),
    .run_o     (run)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int BASE = c * WORDS_PER_CH;

    lat_meas_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .run       (run),
      .clear     (cmd_clear),
      .ev_start  (ev_start[c]),
      .ev_finish (ev_finish[c]),
      .cnt_o     (live[(BASE + int'(ITM_COUNT))*CNT_W +: CNT_W]),
      .sum_o     (live[(BASE + int'(ITM_SUM))*CNT_W +: CNT_W]),
      .sq_lo_o   (live[(BASE + int'(ITM_SQ_LO))*CNT_W +: CNT_W]),
      .sq_hi_o   (live[(BASE + int'(ITM_SQ_HI))*CNT_W +: CNT_W]),
      .min_o     (live[(BASE + int'(ITM_MIN))*CNT_W +: CNT_W]),
      .max_o     (live[(BASE + int'(ITM_MAX))*CNT_W +: CNT_W])
    );
  end

  lat_snap_port #(.CNT_W(CNT_W), .ITEMS(ITEMS)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sample  (cmd_sample),
    .rd_next (rd_next),
    .live_i  (live),
    .rd_data (rd_data)
  );

endmodule

// File: tb/lat_stat_acc_bench.sv
module lat_stat_acc_bench;

  localparam int NCH = 2;
  localparam int W   = 8;
  localparam int NIT = NCH * 6;

  logic           clk;
  logic           rst_n;
  logic           cmd_go, cmd_halt, cmd_clear, cmd_sample, trig_go, trig_halt;
  logic [NCH-1:0] ev_start, ev_finish;
  logic           rd_next;
  logic [W-1:0]   rd_data;

  int checks;
  int errors;
  bit done_flag;
  bit run_m;
  longint n_m[NCH], sum_m[NCH], sq_m[NCH], mn_m[NCH], mx_m[NCH];
  longint n_s[NCH], sum_s[NCH], sq_s[NCH], mn_s[NCH], mx_s[NCH];

  lat_stat_acc #(.NUM_CH(NCH), .CNT_W(W)) u_lat_stat_acc (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_halt(cmd_halt), .cmd_clear(cmd_clear), .cmd_sample(cmd_sample),
    .trig_go(trig_go), .trig_halt(trig_halt),
    .ev_start(ev_start), .ev_finish(ev_finish),
    .rd_next(rd_next), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      n_m[c] = 0; sum_m[c] = 0; sq_m[c] = 0; mn_m[c] = 255; mx_m[c] = 0;
    end
  endtask

  task automatic model_record(input int c, input int lat);
    if (run_m) begin
      n_m[c]++;
      sum_m[c] += lat;
      sq_m[c]  += lat * lat;
      if (lat < mn_m[c]) mn_m[c] = lat;
      if (lat > mx_m[c]) mx_m[c] = lat;
    end
  endtask

  function automatic longint exp_item(input int i);
    int c;
    int k;
    c = i / 6;
    k = i % 6;
    case (k)
      0:       return n_s[c] % 256;
      1:       return sum_s[c] % 256;
      2:       return sq_s[c] % 256;
      3:       return (sq_s[c] / 256) % 256;
      4:       return mn_s[c];
      default: return mx_s[c];
    endcase
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pulse(input bit g, input bit h, input bit c, input bit tg, input bit th);
    @(negedge clk);
    cmd_go = g; cmd_halt = h; cmd_clear = c; trig_go = tg; trig_halt = th;
    @(negedge clk);
    cmd_go = 0; cmd_halt = 0; cmd_clear = 0; trig_go = 0; trig_halt = 0;
    if (h || th) run_m = 0;
    else if (g || tg) run_m = 1;
    if (c) model_clear();
  endtask

  task automatic measure(input int c, input int lat);
    @(negedge clk);
    ev_start[c] = 1'b1;
    if (lat == 0) ev_finish[c] = 1'b1;
    @(negedge clk);
    ev_start[c] = 1'b0;
    ev_finish[c] = 1'b0;
    if (lat > 0) begin
      repeat (lat - 1) @(negedge clk);
      ev_finish[c] = 1'b1;
      @(negedge clk);
      ev_finish[c] = 1'b0;
    end
    model_record(c, lat);
  endtask

  // Reads all words; with do_sample a fresh capture is taken first (R8, R9).
  task automatic read_all(input string req, input bit do_sample);
    if (do_sample) begin
      @(negedge clk);
      cmd_sample = 1'b1;
      @(negedge clk);
      cmd_sample = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        n_s[c] = n_m[c]; sum_s[c] = sum_m[c]; sq_s[c] = sq_m[c];
        mn_s[c] = mn_m[c]; mx_s[c] = mx_m[c];
      end
    end
    for (int i = 0; i < NIT; i++) begin
      check(req, rd_data, exp_item(i));
      rd_next = 1'b1;
      @(negedge clk);
    end
    rd_next = 1'b0;
    check("R9 wrap", rd_data, exp_item(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done_flag = 0; run_m = 0;
    cmd_go = 0; cmd_halt = 0; cmd_clear = 0; cmd_sample = 0; trig_go = 0; trig_halt = 0;
    ev_start = '0; ev_finish = '0; rd_next = 0;
    model_clear();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: reset values
    read_all("R5 reset state", 1'b1);

    // R1: not running, measurement ignored
    measure(0, 3);
    read_all("R1 idle ignores", 1'b1);

    // R1 go; R2 R3 R4 R10 sweep with overlapping channels
    pulse(1, 0, 0, 0, 0);
    for (int l = 0; l <= 14; l++) begin
      fork
        measure(0, l);
        measure(1, 14 - l);
      join
      read_all("R2 R3 R10 sweep", 1'b1);
    end

    // R4: large latency pushes the square sum into the high word
    measure(0, 200);
    read_all("R4 wide squares", 1'b1);

    // R6: second start ignored, latency counted from the first
    @(negedge clk); ev_start[0] = 1'b1;
    @(negedge clk); ev_start[0] = 1'b0;
    @(negedge clk); ev_start[0] = 1'b1;
    @(negedge clk); ev_start[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); ev_finish[0] = 1'b1;
    @(negedge clk); ev_finish[0] = 1'b0;
    model_record(0, 5);
    // R6: lone finish ignored
    @(negedge clk); ev_finish[1] = 1'b1;
    @(negedge clk); ev_finish[1] = 1'b0;
    read_all("R6 extra start and lone finish", 1'b1);

    // R1: cross-trigger halt stops accumulation, trigger go resumes
    pulse(0, 0, 0, 0, 1);
    measure(1, 4);
    read_all("R1 trig halt", 1'b1);
    pulse(0, 0, 0, 1, 0);
    measure(1, 9);
    read_all("R1 trig go", 1'b1);

    // R1: finish after a halt closes without recording
    @(negedge clk); ev_start[0] = 1'b1;
    @(negedge clk); ev_start[0] = 1'b0;
    pulse(0, 1, 0, 0, 0);
    @(negedge clk); ev_finish[0] = 1'b1;
    @(negedge clk); ev_finish[0] = 1'b0;
    pulse(1, 0, 0, 0, 0);
    measure(0, 2);
    read_all("R1 halted finish", 1'b1);

    // R1: go and halt together leave the run state off
    pulse(1, 1, 0, 0, 0);
    measure(0, 6);
    read_all("R1 halt wins", 1'b1);
    pulse(1, 0, 0, 0, 0);

    // R8: capture then keep measuring; buffer keeps old copy
    read_all("R8 capture", 1'b1);
    measure(0, 7);
    measure(1, 1);
    read_all("R8 frozen copy", 1'b0);
    read_all("R8 new capture", 1'b1);

    // R7: clear abandons the open window
    @(negedge clk); ev_start[0] = 1'b1;
    @(negedge clk); ev_start[0] = 1'b0;
    pulse(0, 0, 1, 0, 0);
    @(negedge clk); ev_finish[0] = 1'b1;
    @(negedge clk); ev_finish[0] = 1'b0;
    read_all("R7 clear", 1'b1);

    // R7: finish in the clear cycle is not recorded
    @(negedge clk); ev_start[1] = 1'b1;
    @(negedge clk); ev_start[1] = 1'b0;
    @(negedge clk); ev_finish[1] = 1'b1; cmd_clear = 1'b1;
    @(negedge clk); ev_finish[1] = 1'b0; cmd_clear = 1'b0;
    model_clear();
    measure(1, 3);
    read_all("R7 clear beats finish", 1'b1);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule